// File: doc/BRIEF.md
# Reset, Halt and Wake-up Sequencer

This block decides when a small microcontroller core may execute. It turns a power-on event, an active-low external reset pin, a watchdog time-out and a halt request from the core into four controls. The first is a full chip reset. The second is a partial reset that restarts only the program counter and stack pointer. The third enables the system oscillator, and the fourth is a run enable for the CPU. Two sticky status flags, time-out and power-down, record the cause of the most recent restart so that software can tell the restart types apart.

Halt stops the oscillator and keeps every stored value. Two events end halt. One is a watchdog time-out. The other is a falling edge on any wake-capable pin whose mask bit is set. A settle timer holds the CPU stopped while the oscillator recovers. The timer runs after power-up and after every wake from halt. It is skipped when the core restarts from the external pin or from a watchdog time-out during normal running.

Top module: `rhw_ctrl`

## Requirements
- R1: After power-on, `chip_rst` is 1, `cpu_run` is 0, and both flags are 0 for exactly `SETTLE_CYC` (default 1024) clock cycles. Then `cpu_run` rises and `chip_rst` falls.
- R2: While `ext_rst_n` is 0, `chip_rst` is 1 and `cpu_run` is 0 from the next cycle on, in every state and whatever the other inputs do. Both flags keep their values. One cycle after the pin is released, `cpu_run` is 1, with no settle delay.
- R3: A `halt_cmd` while running sets `osc_en` and `cpu_run` to 0, sets `flag_pd` and clears `flag_to` on the next cycle.
- R4: A `wdt_tmo` while running gives `chip_rst` for one cycle. On that cycle `flag_to` is set and `flag_pd` keeps its value. `cpu_run` returns on the cycle after, with no settle delay.
- R5: A `wdt_tmo` during halt turns the oscillator on and leaves both flags at 1. `pc_sp_rst` is 1 and `chip_rst` is 0 for the whole settle period.
- R6: During halt, a falling edge on `wake_pins[i]` with `wake_mask[i]` = 1 turns `osc_en` on at the third clock edge after the pin falls. Neither reset is asserted, `flag_to` stays 0 and `flag_pd` stays 1.
- R7: Wake pins are ignored in three cases: a falling edge on a pin whose mask bit is 0, a rising edge on any pin, and an edge that happens while the block is not halted. In each case the block stays halted.
- R8: After any wake from halt, `osc_en` is 1 and `cpu_run` is 0 for exactly `SETTLE_CYC` cycles. Then `cpu_run` rises.
- R9: A `clrwdt_cmd` while running clears `flag_pd` and leaves `flag_to` unchanged.
- R10: When several commands arrive together while running, the priority is `wdt_tmo`, then `halt_cmd`, then `clrwdt_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| halt_cmd | input | 1 | Halt request from the core, one cycle |
| clrwdt_cmd | input | 1 | Clear-watchdog request from the core |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| wake_pins | input | WAKE_W | Asynchronous wake-capable port pins |
| wake_mask | input | WAKE_W | Per-pin wake enable |
| chip_rst | output | 1 | Full chip reset |
| pc_sp_rst | output | 1 | Reset of program counter and stack pointer only |
| osc_en | output | 1 | System oscillator enable |
| cpu_run | output | 1 | CPU execution enable |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
Two flag combinations are hard to reach: time-out and power-down both set, and a pin reset while halted. Each needs a chain of earlier restarts, so the stimulus first halts, wakes through the watchdog, and only then applies the external pin. Ignored edges are also hard to observe, because the three-flop pin path hides them for several cycles. The stimulus therefore holds halt well past that latency, and randomly masked pin drops are checked at the oscillator enable.

// File: rtl/rhw_pkg.sv
package rhw_pkg;
   typedef enum logic [2:0] {
      ST_PUP  = 3'd0,   // power-up settle, full reset held
      ST_PIN  = 3'd1,   // external pin held low
      ST_WRST = 3'd2,   // one-cycle watchdog reset while running
      ST_RUN  = 3'd3,
      ST_HALT = 3'd4,
      ST_WAKE = 3'd5    // settle after wake from halt
   } rhw_state_t;
endpackage

// File: rtl/rhw_wake_detect.sv
module rhw_wake_detect #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         por,
   input  logic [W-1:0] pins,
   input  logic [W-1:0] mask,
   output logic         hit
);
   localparam int DEPTH = STAGES + 1;

   if (W < 1) begin : g_bad_w
      $error("rhw_wake_detect: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("rhw_wake_detect: STAGES must be at least 2");
   end

   logic [W-1:0] chain [DEPTH];

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
      end else begin
         chain[0] <= pins;
         for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
   end

   // falling edge: older copy high, newer copy low
   logic [W-1:0] fall;
   assign fall = chain[DEPTH-1] & ~chain[DEPTH-2];
   assign hit  = |(fall & mask);
endmodule

// File: rtl/rhw_settle_timer.sv
module rhw_settle_timer #(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic por,
   input  logic en,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("rhw_settle_timer: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge por) begin
      if (por)          cnt <= '0;
      else if (!en)     cnt <= '0;
      else if (!done)   cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LAST);
endmodule

// File: rtl/rhw_ctrl.sv
module rhw_ctrl
   import rhw_pkg::*;
#(
   parameter int WAKE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 1024
) (
   input  logic              clk,
   input  logic              por,
   input  logic              ext_rst_n,
   input  logic              halt_cmd,
   input  logic              clrwdt_cmd,
   input  logic              wdt_tmo,
   input  logic [WAKE_W-1:0] wake_pins,
   input  logic [WAKE_W-1:0] wake_mask,
   output logic              chip_rst,
   output logic              pc_sp_rst,
   output logic              osc_en,
   output logic              cpu_run,
   output logic              flag_to,
   output logic              flag_pd
);
   rhw_state_t st, st_n;
   logic to_n, pd_n, wdt_wake, wdt_wake_n;
   logic pin_hit, settle_done, settling;

   rhw_wake_detect #(.W(WAKE_W), .STAGES(SYNC_STAGES)) u_wake (
      .clk (clk), .por (por), .pins (wake_pins), .mask (wake_mask), .hit (pin_hit)
   );

   assign settling = (st == ST_PUP) || (st == ST_WAKE);

   rhw_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
      .clk (clk), .por (por), .en (settling), .done (settle_done)
   );

   always_comb begin
      st_n       = st;
      to_n       = flag_to;
      pd_n       = flag_pd;
      wdt_wake_n = wdt_wake;
      if (!ext_rst_n) begin
         st_n       = ST_PIN;
         wdt_wake_n = 1'b0;
      end else begin
         unique case (st)
            ST_PUP:  if (settle_done) st_n = ST_RUN;
            ST_PIN:  st_n = ST_RUN;
            ST_WRST: st_n = ST_RUN;
            ST_RUN: begin
               if (wdt_tmo) begin
                  st_n = ST_WRST;
                  to_n = 1'b1;
               end else if (halt_cmd) begin
                  st_n = ST_HALT;
                  pd_n = 1'b1;
                  to_n = 1'b0;
               end else if (clrwdt_cmd) begin
                  pd_n = 1'b0;
               end
            end
            ST_HALT: begin
               if (wdt_tmo) begin
                  st_n       = ST_WAKE;
                  to_n       = 1'b1;
                  wdt_wake_n = 1'b1;
               end else if (pin_hit) begin
                  st_n       = ST_WAKE;
                  wdt_wake_n = 1'b0;
               end
            end
            ST_WAKE: begin
               if (settle_done) begin
                  st_n       = ST_RUN;
                  wdt_wake_n = 1'b0;
               end
            end
            default: st_n = ST_PUP;
         endcase
      end
   end

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         st       <= ST_PUP;
         flag_to  <= 1'b0;
         flag_pd  <= 1'b0;
         wdt_wake <= 1'b0;
      end else begin
         st       <= st_n;
         flag_to  <= to_n;
         flag_pd  <= pd_n;
         wdt_wake <= wdt_wake_n;
      end
   end

   assign chip_rst  = (st == ST_PUP) || (st == ST_PIN) || (st == ST_WRST);
   assign pc_sp_rst = (st == ST_WAKE) && wdt_wake;
   assign osc_en    = (st != ST_HALT);
   assign cpu_run   = (st == ST_RUN);
endmodule

// File: rtl/rhw_ctrl_chk.sv
module rhw_ctrl_chk (
   input logic clk,
   input logic por,
   input logic ext_rst_n,
   input logic halt_cmd,
   input logic clrwdt_cmd,
   input logic wdt_tmo,
   input logic chip_rst,
   input logic pc_sp_rst,
   input logic osc_en,
   input logic cpu_run,
   input logic flag_to,
   input logic flag_pd
);
   p_pin_hold_r2: assert property (@(posedge clk) disable iff (por)
      !ext_rst_n |=> chip_rst && !cpu_run && $stable(flag_to) && $stable(flag_pd));

   p_halt_entry_r3: assert property (@(posedge clk) disable iff (por)
      cpu_run && halt_cmd && !wdt_tmo && ext_rst_n |=> !osc_en && flag_pd && !flag_to);

   p_wdt_run_r4: assert property (@(posedge clk) disable iff (por)
      cpu_run && wdt_tmo && ext_rst_n |=> chip_rst && flag_to && $stable(flag_pd));

   p_wdt_wake_r5: assert property (@(posedge clk) disable iff (por)
      !osc_en && wdt_tmo && ext_rst_n |=> osc_en && pc_sp_rst && flag_to && flag_pd);

   p_partial_only_r5: assert property (@(posedge clk) disable iff (por)
      pc_sp_rst |-> !chip_rst && !cpu_run && osc_en);

   p_clear_pd_r9: assert property (@(posedge clk) disable iff (por)
      cpu_run && clrwdt_cmd && !halt_cmd && !wdt_tmo && ext_rst_n |=> !flag_pd);
endmodule

bind rhw_ctrl rhw_ctrl_chk u_chk (
   .clk (clk), .por (por), .ext_rst_n (ext_rst_n), .halt_cmd (halt_cmd),
   .clrwdt_cmd (clrwdt_cmd), .wdt_tmo (wdt_tmo), .chip_rst (chip_rst),
   .pc_sp_rst (pc_sp_rst), .osc_en (osc_en), .cpu_run (cpu_run),
   .flag_to (flag_to), .flag_pd (flag_pd)
);

// File: tb/tb_rhw_ctrl.sv
module tb_rhw_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int SETTLE     = 1024;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic ext_rst_n = 1'b1;
   logic halt_cmd = 1'b0, clrwdt_cmd = 1'b0, wdt_tmo = 1'b0;
   logic [W-1:0] wake_pins = '1;
   logic [W-1:0] wake_mask = '0;
   logic chip_rst, pc_sp_rst, osc_en, cpu_run, flag_to, flag_pd;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rhw_ctrl #(.WAKE_W(W), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE)) dut (
      .clk (clk), .por (por), .ext_rst_n (ext_rst_n), .halt_cmd (halt_cmd),
      .clrwdt_cmd (clrwdt_cmd), .wdt_tmo (wdt_tmo), .wake_pins (wake_pins),
      .wake_mask (wake_mask), .chip_rst (chip_rst), .pc_sp_rst (pc_sp_rst),
      .osc_en (osc_en), .cpu_run (cpu_run), .flag_to (flag_to), .flag_pd (flag_pd)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_wake(input logic [W-1:0] m, input int b);
      return m[b];
   endfunction

   // count negedges until cpu_run is seen high
   task automatic wait_run(output int n);
      n = 0;
      while (cpu_run !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic pulse_halt();   halt_cmd = 1; @(negedge clk); halt_cmd = 0; endtask
   task automatic pulse_wdt();    wdt_tmo = 1;  @(negedge clk); wdt_tmo = 0;  endtask
   task automatic pulse_clr();    clrwdt_cmd = 1; @(negedge clk); clrwdt_cmd = 0; endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 chip_rst in power-up", chip_rst, 1);
      chk("R1 cpu_run in power-up", cpu_run, 0);
      chk("R1 flags after power-up", {flag_to, flag_pd}, 0);
      por = 0;
      wait_run(n);
      chk("R1 power-up settle length", n, SETTLE);
      chk("R1 chip_rst released", chip_rst, 0);

      // R3 halt
      pulse_halt();
      chk("R3 osc_en off", osc_en, 0);
      chk("R3 flags to/pd", {flag_to, flag_pd}, 1);

      // R7 unmasked falling edge ignored
      wake_mask = 8'h01;
      wake_pins[3] = 0;
      repeat (8) @(negedge clk);
      chk("R7 unmasked edge ignored", osc_en, 0);
      wake_pins[3] = 1;
      // R7 rising edge on masked pin ignored
      wake_mask = 8'h00;
      wake_pins[0] = 0;
      repeat (6) @(negedge clk);
      wake_mask = 8'h01;
      wake_pins[0] = 1;
      repeat (8) @(negedge clk);
      chk("R7 rising edge ignored", osc_en, 0);

      // R6 masked falling edge wakes after three edges
      wake_pins[0] = 0;
      repeat (2) @(negedge clk);
      chk("R6 still halted after two edges", osc_en, 0);
      @(negedge clk);
      chk("R6 woke on third edge", osc_en, 1);
      chk("R6 no resets", {chip_rst, pc_sp_rst}, 0);
      chk("R6 flags", {flag_to, flag_pd}, 1);
      wait_run(n);
      chk("R8 pin wake settle length", n, SETTLE);
      wake_pins[0] = 1;

      // R9 clear watchdog
      pulse_clr();
      chk("R9 pd cleared, to kept", {flag_to, flag_pd}, 0);

      // R4 watchdog in run
      pulse_wdt();
      chk("R4 one-cycle chip_rst", chip_rst, 1);
      chk("R4 to set pd kept", {flag_to, flag_pd}, 2);
      @(negedge clk);
      chk("R4 run resumes without settle", cpu_run, 1);

      // R5 watchdog wake from halt
      pulse_halt();
      pulse_wdt();
      chk("R5 partial reset", pc_sp_rst, 1);
      chk("R5 no chip reset", chip_rst, 0);
      chk("R5 flags both set", {flag_to, flag_pd}, 3);
      chk("R8 oscillator on in settle", osc_en, 1);
      wait_run(n);
      chk("R5 watchdog wake settle length", n, SETTLE);
      chk("R5 partial reset released", pc_sp_rst, 0);

      // R2 pin reset in run keeps flags; other inputs ignored
      ext_rst_n = 0;
      @(negedge clk);
      chk("R2 chip_rst while pin low", chip_rst, 1);
      halt_cmd = 1; wdt_tmo = 1;
      repeat (3) @(negedge clk);
      halt_cmd = 0; wdt_tmo = 0;
      chk("R2 priority over halt/wdt", {chip_rst, cpu_run, osc_en}, 3'b101);
      chk("R2 flags unchanged", {flag_to, flag_pd}, 3);
      ext_rst_n = 1;
      @(negedge clk);
      chk("R2 run without settle", cpu_run, 1);

      // R2 pin reset during halt
      pulse_clr();
      pulse_halt();
      ext_rst_n = 0;
      @(negedge clk);
      ext_rst_n = 1;
      @(negedge clk);
      chk("R2 pin wake from halt runs", cpu_run, 1);
      chk("R2 pin wake flags to=0 pd=1", {flag_to, flag_pd}, 1);

      // R10 priorities
      wdt_tmo = 1; halt_cmd = 1; clrwdt_cmd = 1;
      @(negedge clk);
      wdt_tmo = 0; halt_cmd = 0; clrwdt_cmd = 0;
      chk("R10 watchdog wins", {chip_rst, flag_to, flag_pd}, 3'b111);
      @(negedge clk);
      halt_cmd = 1; clrwdt_cmd = 1;
      @(negedge clk);
      halt_cmd = 0; clrwdt_cmd = 0;
      chk("R10 halt beats clear", {osc_en, flag_to, flag_pd}, 3'b001);
      pulse_wdt();
      wait_run(n);

      // R7 edge outside halt ignored
      wake_mask = 8'h02;
      wake_pins[1] = 0;
      repeat (2) @(negedge clk);
      pulse_halt();
      repeat (8) @(negedge clk);
      chk("R7 edge before halt ignored", osc_en, 0);
      pulse_wdt();
      wait_run(n);
      wake_pins[1] = 1;
      repeat (4) @(negedge clk);

      // random masks and pins
      for (int it = 0; it < 16; it++) begin
         logic [W-1:0] m;
         int b;
         m = W'($urandom);
         b = int'($urandom % W);
         wake_mask = m;
         @(negedge clk);
         pulse_halt();
         wake_pins[b] = 0;
         repeat (4) @(negedge clk);
         chk(exp_wake(m, b) ? "R6 random masked wake" : "R7 random masked-off pin",
             osc_en, int'(exp_wake(m, b)));
         if (!osc_en) pulse_wdt();
         wait_run(n);
         chk("R8 random settle ends in run", cpu_run, 1);
         wake_pins[b] = 1;
         repeat (4) @(negedge clk);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule